// File: doc/BRIEF.md
# Instruction Fetch and Sequencing Unit

This unit owns the program counter of a simple in-order processor and walks a fixed three-phase machine cycle: fetch, increment, execute. In the fetch phase it puts the counter on an instruction memory port and waits for the memory to signal ready. It then captures the returned 32-bit word in an instruction register. In the increment phase it moves the counter forward by one instruction, which is four bytes. In the execute phase it presents the held word to the decoder. At that point the counter already points at the next sequential instruction.

A jump request is sampled only in the execute phase. If the target is word aligned, it replaces the sequential counter value, and the next fetch comes from the target. If the target is not word aligned, the counter keeps its sequential value and an alignment-error flag is raised. The unit gives no meaning to the fetched word. Whatever arrives from memory is held and handed on as an instruction.

Top module: `ifetch_seq`

## Requirements
- R1: Asynchronous reset (rst_ni low) sets the counter to 0x00400000, the phase to fetch, the instruction register to zero and the alignment-error flag to zero.
- R2: `imem_req_o` is high exactly in the fetch phase, and while it is high `imem_addr_o` equals the counter.
- R3: In the fetch phase the unit holds both the phase and the counter until a clock edge with `imem_ready_i` high. On that edge it latches `imem_data_i` and moves to the increment phase.
- R4: The increment phase adds 4 to the counter on its clock edge. No other phase changes the counter, apart from an accepted jump in execute (R7).
- R5: Without jumps, instructions are fetched from 0x00400000, 0x00400004 and 0x00400008 in that order. While each instruction executes, `pc_o` equals its fetch address plus 4.
- R6: `phase_o` encodes fetch as 0, increment as 1 and execute as 2. The phases always follow the order 0, 1, 2, 0, and execute always lasts exactly one cycle.
- R7: A jump request in execute whose target has bits [1:0] equal to 0 loads the counter with the target, so the next fetch address is the target.
- R8: A jump request in execute whose target has nonzero bits [1:0] leaves the counter at its sequential value and sets `align_err_o`. The flag is cleared at the next execute phase that carries no misaligned jump.
- R9: `jump_i` has no effect on the counter or the flag in the fetch and increment phases.
- R10: The instruction register changes only on a fetch edge with ready high, so `instr_o` is stable through increment and execute. Any word is accepted, for example 0x01095020.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| imem_req_o | output | 1 | Instruction memory request, high in fetch |
| imem_addr_o | output | 32 | Instruction memory byte address |
| imem_data_i | input | 32 | Instruction word returned by memory |
| imem_ready_i | input | 1 | Memory word valid for this fetch |
| jump_i | input | 1 | Jump request, honoured in execute |
| jump_target_i | input | 32 | Jump destination byte address |
| instr_o | output | 32 | Instruction register contents |
| pc_o | output | 32 | Current program counter |
| phase_o | output | 2 | Cycle phase: 0 fetch, 1 increment, 2 execute |
| align_err_o | output | 1 | Misaligned jump target seen in last execute |

## Verification
The hardest situations to produce are the interactions between a jump and the phase it arrives in. These are a misaligned target that must not disturb the counter, an aligned jump that follows a flagged one and must clear the flag, and jump requests raised during fetch stalls or increment that must be ignored. The stimulus follows the phase output on every cycle. It issues aligned and misaligned jumps on a rotating schedule of execute phases, and it asserts stray jumps in the other phases. It also gates ready on a pattern that is not periodic with the three-phase cycle, so that stalls land both in front of jump cycles and after them.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;
  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_INCR  = 2'd1,
    PH_EXEC  = 2'd2
  } phase_e;
endpackage

// File: rtl/ifetch_phase.sv
module ifetch_phase
  import ifetch_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   mem_ready_i,
  output phase_e phase_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_FETCH: if (mem_ready_i) phase_d = PH_INCR;
      PH_INCR:  phase_d = PH_EXEC;
      PH_EXEC:  phase_d = PH_FETCH;
      default:  phase_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_FETCH;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/ifetch_pc.sv
module ifetch_pc
  import ifetch_pkg::*;
#(
  parameter int unsigned          ADDR_W     = 32,
  parameter logic [ADDR_W-1:0]    RESET_PC   = 32'h0040_0000,
  parameter int unsigned          STEP       = 4,
  parameter int unsigned          ALIGN_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_i,
  input  logic              jump_i,
  input  logic [ADDR_W-1:0] jump_target_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              align_err_o
);
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              err_q, err_d;
  logic              tgt_misaligned;

  generate
    if (ALIGN_BITS == 0) begin : g_noalign
      assign tgt_misaligned = 1'b0;
    end else begin : g_align
      assign tgt_misaligned = |jump_target_i[ALIGN_BITS-1:0];
    end
  endgenerate

  always_comb begin
    pc_d  = pc_q;
    err_d = err_q;
    unique case (phase_i)
      PH_INCR: pc_d = pc_q + ADDR_W'(STEP);
      PH_EXEC: begin
        err_d = jump_i && tgt_misaligned;
        if (jump_i && !tgt_misaligned) pc_d = jump_target_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= RESET_PC;
      err_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      err_q <= err_d;
    end
  end

  assign pc_o        = pc_q;
  assign align_err_o = err_q;
endmodule

// File: rtl/ifetch_ir.sv
module ifetch_ir #(
  parameter int unsigned INSTR_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [INSTR_W-1:0] data_i,
  output logic [INSTR_W-1:0] ir_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ir_o <= '0;
    else if (load_i) ir_o <= data_i;
  end
endmodule

// File: rtl/ifetch_seq.sv
module ifetch_seq
  import ifetch_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 32,
  parameter int unsigned       INSTR_W  = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0040_0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic               imem_req_o,
  output logic [ADDR_W-1:0]  imem_addr_o,
  input  logic [INSTR_W-1:0] imem_data_i,
  input  logic               imem_ready_i,
  input  logic               jump_i,
  input  logic [ADDR_W-1:0]  jump_target_i,
  output logic [INSTR_W-1:0] instr_o,
  output logic [ADDR_W-1:0]  pc_o,
  output logic [1:0]         phase_o,
  output logic               align_err_o
);
  localparam int unsigned STEP       = INSTR_W / 8;
  localparam int unsigned ALIGN_BITS = $clog2(STEP);

  phase_e            phase;
  logic [ADDR_W-1:0] pc;
  logic              fetch_hit;

  ifetch_phase u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mem_ready_i (imem_ready_i),
    .phase_o     (phase)
  );

  ifetch_pc #(
    .ADDR_W     (ADDR_W),
    .RESET_PC   (RESET_PC),
    .STEP       (STEP),
    .ALIGN_BITS (ALIGN_BITS)
  ) u_pc (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .phase_i       (phase),
    .jump_i        (jump_i),
    .jump_target_i (jump_target_i),
    .pc_o          (pc),
    .align_err_o   (align_err_o)
  );

  assign fetch_hit = (phase == PH_FETCH) && imem_ready_i;

  ifetch_ir #(.INSTR_W(INSTR_W)) u_ir (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (fetch_hit),
    .data_i (imem_data_i),
    .ir_o   (instr_o)
  );

  assign imem_req_o  = (phase == PH_FETCH);
  assign imem_addr_o = pc;
  assign pc_o        = pc;
  assign phase_o     = phase;
endmodule

// File: rtl/ifetch_seq_chk.sv
module ifetch_seq_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned INSTR_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               imem_req_o,
  input logic [ADDR_W-1:0]  imem_addr_o,
  input logic [INSTR_W-1:0] imem_data_i,
  input logic               imem_ready_i,
  input logic               jump_i,
  input logic [ADDR_W-1:0]  jump_target_i,
  input logic [INSTR_W-1:0] instr_o,
  input logic [ADDR_W-1:0]  pc_o,
  input logic [1:0]         phase_o,
  input logic               align_err_o
);
  assert_req_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_req_o |-> (imem_addr_o == pc_o && phase_o == 2'd0));

  assert_fetch_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd0 && !imem_ready_i) |=> (phase_o == 2'd0 && $stable(pc_o)));

  assert_fetch_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd0 && imem_ready_i) |=> (phase_o == 2'd1 && instr_o == $past(imem_data_i)));

  assert_incr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd1) |=> (phase_o == 2'd2 && pc_o == $past(pc_o) + ADDR_W'(INSTR_W / 8)));

  assert_exec_to_fetch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd2) |=> (phase_o == 2'd0));

  assert_phase_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o != 2'd3);

  assert_jump_taken_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd2 && jump_i && jump_target_i[1:0] == 2'b00) |=> (pc_o == $past(jump_target_i)));

  assert_misalign_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd2 && jump_i && jump_target_i[1:0] != 2'b00) |=> (align_err_o && $stable(pc_o)));

  assert_flag_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != 2'd2) |=> $stable(align_err_o));

  assert_ir_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(phase_o == 2'd0 && imem_ready_i) |=> $stable(instr_o));
endmodule

bind ifetch_seq ifetch_seq_chk #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_chk (.*);

// File: tb/sim_ifetch_seq.sv
`timescale 1ns/1ps
module sim_ifetch_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [31:0] addr;
  logic [31:0] rdata;
  logic        ready;
  logic        jump;
  logic [31:0] target;
  logic [31:0] instr;
  logic [31:0] pc;
  logic [1:0]  phase;
  logic        aerr;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (a == 32'h0040_0008) return 32'h0109_5020;
    return (a ^ 32'h5A5A_0000) + 32'h0000_0011;
  endfunction

  always_comb rdata = mem_word(addr);

  ifetch_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .imem_req_o(req), .imem_addr_o(addr),
    .imem_data_i(rdata), .imem_ready_i(ready), .jump_i(jump),
    .jump_target_i(target), .instr_o(instr), .pc_o(pc), .phase_o(phase),
    .align_err_o(aerr)
  );

  // behavioural reference
  int          m_ph;
  logic [31:0] m_pc, m_ir;
  logic        m_err;
  logic [31:0] fetched[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_pc = 32'h0040_0000; m_ir = 0; m_err = 0;
    end else begin
      case (m_ph)
        0: if (ready) begin m_ir = mem_word(m_pc); fetched.push_back(m_pc); m_ph = 1; end
        1: begin m_pc = m_pc + 4; m_ph = 2; end
        default: begin
          if (jump && target[1:0] == 2'b00) begin m_pc = target; m_err = 0; end
          else m_err = jump;
          m_ph = 0;
        end
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(pc === m_pc, "R4/R9 pc", pc, m_pc);
      check(phase === 2'(m_ph), "R6 phase", 32'(phase), m_ph);
      check(instr === m_ir, "R10 instr", instr, m_ir);
      check(aerr === m_err, "R8 align_err", 32'(aerr), 32'(m_err));
      check(req === (m_ph == 0), "R2 req", 32'(req), 32'(m_ph == 0));
      if (m_ph == 0) check(addr === m_pc, "R2/R7 addr", addr, m_pc);
      if (phase == 2'd2 && instr == 32'h0109_5020)
        check(pc === 32'h0040_000C, "R5 pc during exec of add", pc, 32'h0040_000C);
    end
  end

  initial begin
    rst_n = 0; ready = 0; jump = 0; target = 0;
    repeat (3) @(negedge clk);
    check(pc === 32'h0040_0000, "R1 pc", pc, 32'h0040_0000);
    check(phase === 2'd0, "R1 phase", 32'(phase), 0);
    check(instr === 32'h0, "R1 instr", instr, 0);
    check(aerr === 1'b0, "R1 align_err", 32'(aerr), 0);
    rst_n = 1;
    // stall in fetch with stray jump
    for (int i = 0; i < 4; i++) begin
      jump = 1; target = 32'h0000_0040;
      @(negedge clk);
      check(phase === 2'd0, "R3 stall phase", 32'(phase), 0);
      check(addr === 32'h0040_0000, "R3/R9 stall addr", addr, 32'h0040_0000);
    end
    jump = 0; ready = 1;
    repeat (9) @(negedge clk);
    check(fetched.size() >= 3, "R5 fetch count", fetched.size(), 3);
    if (fetched.size() >= 3) begin
      check(fetched[0] === 32'h0040_0000, "R5 first", fetched[0], 32'h0040_0000);
      check(fetched[1] === 32'h0040_0004, "R5 second", fetched[1], 32'h0040_0004);
      check(fetched[2] === 32'h0040_0008, "R5 third", fetched[2], 32'h0040_0008);
    end
    // mixed traffic
    begin
      int n_exec = 0;
      for (int k = 0; k < 600; k++) begin
        ready = (k % 7 != 2) && (k % 11 != 5);
        if (phase == 2'd2) begin
          n_exec++;
          case (n_exec % 6)
            1: begin jump = 1; target = 32'h0040_0000 + 32'(n_exec * 64); end   // R7
            3: begin jump = 1; target = 32'h0040_0102 + 32'(n_exec % 2); end    // R8
            4: begin jump = (n_exec % 12 == 4); target = 32'h0041_0003; end      // R8 back to back
            default: begin jump = 0; target = 32'hFFFF_FFFF; end
          endcase
        end else begin
          jump = (k % 3 == 0); target = 32'h0000_0010 + 32'(k % 4);              // R9
        end
        @(negedge clk);
      end
    end
    finished = 1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule